// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block is a master-clocked serial port that moves one byte at a time over a single data line, least significant bit first. It drives its own shift clock on a separate output. The data line is split into an output, an output enable and an input, so the pad and its direction logic stay outside the block. The shift clock period is either 4 or 12 system clocks, and the choice is taken at the moment a transfer starts.

Software talks to the port through a write strobe with a one-bit address and a combinational read path. A write to the data address starts a transmit. Setting the receive enable while the receive-full flag is clear starts a receive. Each finished receive parks the byte in a buffer and raises the full flag. The port starts no further receive until software writes a zero to that flag, and then the next byte is shifted in at once. A finished transmit raises a sticky done flag.

Top module: `sps_shift_port`

## Requirements
- R1: After reset the shift clock output is 1, the output enable is 0, and a read of address 1 returns 0.
- R2: A write to address 0 while idle sends the written byte least significant bit first on `sdOut`, with `sdOe` high for the whole transfer. The shift clock makes exactly 8 rising edges and then stays at 1.
- R3: The shift clock period is 4 system clocks when control bit 3 is 1 and 12 when it is 0. The value of bit 3 at the start of a transfer holds for that whole transfer, even if bit 3 is rewritten midway.
- R4: During a transmit, each new value on `sdOut` appears exactly one system clock before the falling edge of the shift clock.
- R5: Status bit 1 (transmit done) goes to 1 when a transmit ends. It stays 1 until a control write with bit 1 equal to 0.
- R6: A write to address 0 while a transfer is in progress is ignored: the byte in flight is unchanged and no extra transfer follows.
- R7: With control bit 2 (receive enable) at 1 and status bit 0 (receive full) at 0, the idle port clocks in 8 bits from `sdIn` on the shift clock rising edges, least significant bit first, with `sdOe` held at 0.
- R8: Status bit 0 goes to 1 exactly 12 system clocks after the eighth rising edge of a receive. The received byte is then read at address 0.
- R9: While status bit 0 is 1, the shift clock stays at 1 and the receive buffer keeps its byte. A control write with bit 0 equal to 0 starts the next receive.
- R10: A read of address 1 returns {bit 3 speed, bit 2 receive enable, bit 1 transmit done, bit 0 receive full}, with zeros above. Writing 1 to bit 0 or bit 1 never sets those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 data, 1 control/status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| sdIn | input | 1 | Data line input |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable, high only while transmitting |
| sclk | output | 1 | Shift clock, idles high |

## Verification
A wrong phase or bit counter shows up within one shift clock period. Either the spacing between rising edges is off, or the ninth edge that should never come appears on `sclk`. A wrong shift register or bit order shows up as a wrong byte at the end of a transfer. That is at most 96 system clocks after the start. A wrong wait counter or a stuck gating flag moves the receive-full flag off its exact twelfth clock, or lets the shift clock run while a byte is still unread. Both are seen in the same cycle they happen.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef struct packed {
    logic loadTx;     // capture a byte for sending
    logic driveBit;   // put the next bit on the line
    logic sampleBit;  // take the line value into the receive shifter
    logic commitRx;   // move the received byte into the buffer
  } spsStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TX     = 2'd1,
    ST_RX     = 2'd2,
    ST_RXWAIT = 2'd3
  } spsState_e;
endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 12,
  parameter int MACH_CYC = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regAddr,
  input  logic [3:0]  ctrlWdata,
  output logic        sclk,
  output logic        sdOe,
  output logic        rxFull,
  output logic        txDone,
  output logic        rxEn,
  output logic        fastSel,
  output spsStrobes_t strobes
);
  localparam int PH_W = $clog2(DIV_SLOW + 1);
  localparam int BC_W = $clog2(DATA_W);
  localparam int MC_W = $clog2(MACH_CYC);
  localparam logic [BC_W-1:0] LAST_BIT   = BC_W'(DATA_W - 1);
  localparam logic [PH_W-1:0] DIV_FAST_V = PH_W'(DIV_FAST);
  localparam logic [PH_W-1:0] DIV_SLOW_V = PH_W'(DIV_SLOW);
  localparam logic [MC_W-1:0] WAIT_LAST  = MC_W'(MACH_CYC - 1);

  spsState_e       state;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] curDiv;
  logic [PH_W-1:0] half;
  logic [BC_W-1:0] bitCnt;
  logic [MC_W-1:0] waitCnt;
  logic            sclkQ, sdOeQ, rxFullQ, txDoneQ, rxEnQ, fastQ;

  logic dataWr, ctrlWr, active, phLast, sampleNow, txEnd, rxStart;

  assign dataWr    = regWr && !regAddr;
  assign ctrlWr    = regWr && regAddr;
  assign half      = curDiv >> 1;
  assign active    = (state == ST_TX) || (state == ST_RX);
  assign phLast    = (ph == curDiv - PH_W'(1));
  assign sampleNow = (state == ST_RX) && (ph == half + PH_W'(1));
  assign txEnd     = (state == ST_TX) && phLast && (bitCnt == LAST_BIT);
  assign rxStart   = (state == ST_IDLE) && !dataWr && rxEnQ && !rxFullQ;

  always_comb begin
    strobes.loadTx    = (state == ST_IDLE) && dataWr;
    strobes.driveBit  = (state == ST_TX) && (ph == '0);
    strobes.sampleBit = sampleNow;
    strobes.commitRx  = (state == ST_RXWAIT) && (waitCnt == WAIT_LAST);
  end

  // sequencer: phase within a bit, bit index, post-receive wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ph      <= '0;
      bitCnt  <= '0;
      waitCnt <= '0;
      curDiv  <= DIV_SLOW_V;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (dataWr || rxStart) begin
            state  <= dataWr ? ST_TX : ST_RX;
            ph     <= '0;
            bitCnt <= '0;
            curDiv <= fastQ ? DIV_FAST_V : DIV_SLOW_V;
          end
        end
        ST_TX: begin
          if (phLast) begin
            ph <= '0;
            if (bitCnt == LAST_BIT) state <= ST_IDLE;
            else bitCnt <= bitCnt + BC_W'(1);
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_RX: begin
          if (sampleNow && bitCnt == LAST_BIT) begin
            state   <= ST_RXWAIT;
            ph      <= '0;
            waitCnt <= '0;
          end else if (phLast) begin
            ph     <= '0;
            bitCnt <= bitCnt + BC_W'(1);
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_RXWAIT: begin
          if (strobes.commitRx) state <= ST_IDLE;
          else waitCnt <= waitCnt + MC_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pin registers: clock low for the first half of a bit after phase 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b1;
      sdOeQ <= 1'b0;
    end else begin
      sclkQ <= !(active && ph >= PH_W'(1) && ph <= half);
      if (strobes.loadTx) sdOeQ <= 1'b1;
      else if (txEnd)     sdOeQ <= 1'b0;
    end
  end

  // control and status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFullQ <= 1'b0;
      txDoneQ <= 1'b0;
      rxEnQ   <= 1'b0;
      fastQ   <= 1'b0;
    end else begin
      if (strobes.commitRx)            rxFullQ <= 1'b1;
      else if (ctrlWr && !ctrlWdata[0]) rxFullQ <= 1'b0;
      if (txEnd)                       txDoneQ <= 1'b1;
      else if (ctrlWr && !ctrlWdata[1]) txDoneQ <= 1'b0;
      if (ctrlWr) begin
        rxEnQ <= ctrlWdata[2];
        fastQ <= ctrlWdata[3];
      end
    end
  end

  assign sclk    = sclkQ;
  assign sdOe    = sdOeQ;
  assign rxFull  = rxFullQ;
  assign txDone  = txDoneQ;
  assign rxEn    = rxEnQ;
  assign fastSel = fastQ;

  p_clk_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> sclkQ);
  p_phase_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (ph < curDiv));
  p_div_latched_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(curDiv));
  p_txdone_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneQ && !(ctrlWr && !ctrlWdata[1])) |=> txDoneQ);
  p_rx_not_driven_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX) |-> !sdOeQ);
  p_full_blocks_rx_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxFullQ |-> (state != ST_RX));
endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spsStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxBufQ;
  logic              sdOutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdOutQ  <= 1'b0;
    end else if (strobes.loadTx) begin
      txShift <= wrData;
    end else if (strobes.driveBit) begin
      sdOutQ  <= txShift[0];
      txShift <= txShift >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBufQ  <= '0;
    end else begin
      if (strobes.sampleBit) rxShift <= {sdIn, rxShift[DATA_W-1:1]};
      if (strobes.commitRx)  rxBufQ  <= rxShift;
    end
  end

  assign sdOut = sdOutQ;
  assign rxBuf = rxBufQ;

  p_commit_loads_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitRx |=> (rxBufQ == $past(rxShift)));
  p_buffer_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitRx |=> $stable(rxBufQ));
  p_drive_sample_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.driveBit && strobes.sampleBit));
endmodule

// File: rtl/sps_shift_port.sv
module sps_shift_port
  import sps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 12,
  parameter int MACH_CYC = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              sclk
);
  spsStrobes_t       strobes;
  logic              rxFull, txDone, rxEn, fastSel;
  logic [DATA_W-1:0] rxBuf;

  sps_ctrl #(
    .DATA_W(DATA_W), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .MACH_CYC(MACH_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .ctrlWdata(regWdata[3:0]), .sclk(sclk), .sdOe(sdOe),
    .rxFull(rxFull), .txDone(txDone), .rxEn(rxEn), .fastSel(fastSel),
    .strobes(strobes)
  );

  sps_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWdata),
    .sdIn(sdIn), .sdOut(sdOut), .rxBuf(rxBuf)
  );

  assign regRdata = regAddr ? {{(DATA_W-4){1'b0}}, fastSel, rxEn, txDone, rxFull}
                            : rxBuf;
endmodule

// File: tb/sps_shift_port_tb_top.sv
module sps_shift_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic       regAddr = 1'b1;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sdIn;
  logic       sdOut, sdOe, sclk;

  int errCnt = 0;
  int chkCnt = 0;

  typedef struct { logic [7:0] b; int div; } item_t;
  item_t      txQ[$];
  logic [7:0] rxQ[$];

  // external receive device, armed by the tasks
  logic       rxActive = 1'b0;
  logic [7:0] devByte = 8'h00;
  int         rxDiv = 4;
  logic       rxSeenFull = 1'b0;
  int         strayRises = 0;

  always #5 clk = ~clk;

  sps_shift_port dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .sclk(sclk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic waitStatus(input int idx, input string tag);
    int n = 0;
    regAddr = 1'b1;
    while (n < 400 && regRdata[idx] !== 1'b1) begin
      @(negedge clk); n++;
    end
    check(regRdata[idx] === 1'b1, tag, int'(regRdata[idx]), 1);
  endtask

  task automatic sendByte(input logic [7:0] b, input int div);
    item_t it;
    it.b = b; it.div = div;
    txQ.push_back(it);
    regWrite(1'b0, b);
    regAddr = 1'b1;
  endtask

  // monitor: collects transmitted bits, plays the remote receiver and
  // checks pin timing at mid-cycle samples
  int   sampleIdx = 0, sinceChange = 0, txBits = 0, lastRise = 0;
  int   riseCnt = 0, devIdx = 0, lastRxRise = 0, lastRxEdge = 0;
  logic prevSclk = 1'b1, prevOut = 1'b0, prevOe = 1'b0, changedThisBit = 1'b0;
  logic [7:0] txByte = 8'h00;

  always @(negedge clk) begin
    logic rising, falling;
    sampleIdx++;
    if (!rstN) begin
      sdIn <= 1'b1;
      prevSclk = sclk; prevOut = sdOut; prevOe = sdOe;
    end else begin
      rising  = sclk && !prevSclk;
      falling = !sclk && prevSclk;
      if (sdOut !== prevOut) begin sinceChange = 0; changedThisBit = 1'b1; end
      else sinceChange++;

      if (falling && prevOe && changedThisBit)
        check(sinceChange == 1, "R4 data lead before falling edge", sinceChange, 1);

      if (rising && prevOe) begin
        changedThisBit = 1'b0;
        if (txQ.size() == 0) begin
          check(1'b0, "R6 unexpected transmit clock", 1, 0);
        end else begin
          if (txBits > 0)
            check(sampleIdx - lastRise == txQ[0].div, "R3 transmit clock period",
                  sampleIdx - lastRise, txQ[0].div);
          lastRise = sampleIdx;
          txByte[txBits] = sdOut;
          txBits++;
          if (txBits == 8) begin
            item_t e;
            e = txQ.pop_front();
            check(txByte == e.b, "R2 transmitted byte", int'(txByte), int'(e.b));
            txBits = 0;
          end
        end
      end

      if (!rxActive) begin
        riseCnt = 0; devIdx = 0; rxSeenFull <= 1'b0;
        sdIn <= 1'b1;
        if (rising && !prevOe) strayRises++;
      end else begin
        if (falling && devIdx < 8) begin
          sdIn <= devByte[devIdx];
          devIdx++;
        end
        if (rising && !prevOe) begin
          check(sdOe === 1'b0, "R7 data line not driven during receive", int'(sdOe), 0);
          if (riseCnt > 0)
            check(sampleIdx - lastRxEdge == rxDiv, "R3 receive clock period",
                  sampleIdx - lastRxEdge, rxDiv);
          lastRxEdge = sampleIdx;
          riseCnt++;
          if (riseCnt == 8) lastRxRise = sampleIdx;
        end
        if (riseCnt == 8 && regAddr == 1'b1) begin
          if (sampleIdx - lastRxRise == 11)
            check(regRdata[0] == 1'b0, "R8 full flag not yet set", int'(regRdata[0]), 0);
          if (sampleIdx - lastRxRise == 12) begin
            check(regRdata[0] == 1'b1, "R8 full flag at twelfth clock", int'(regRdata[0]), 1);
            rxSeenFull <= 1'b1;
          end
        end
      end
      prevSclk = sclk; prevOut = sdOut; prevOe = sdOe;
    end
  end

  task automatic recvByte(input logic [7:0] b, input int div, input logic [7:0] ctrlVal);
    int n = 0;
    logic [7:0] e;
    devByte = b; rxDiv = div;
    rxQ.push_back(b);
    rxActive = 1'b1;
    regWrite(1'b1, ctrlVal);
    while (n < 400 && !rxSeenFull) begin @(negedge clk); n++; end
    check(rxSeenFull == 1'b1, "R8 receive completed", int'(rxSeenFull), 1);
    regAddr = 1'b0;
    @(negedge clk);
    e = rxQ.pop_front();
    check(regRdata == e, "R7 received byte", int'(regRdata), int'(e));
    rxActive = 1'b0;
    regAddr = 1'b1;
  endtask

  initial begin
    int st;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1, "R1 shift clock idles high", int'(sclk), 1);
    check(sdOe === 1'b0, "R1 output enable low", int'(sdOe), 0);
    check(regRdata === 8'h00, "R1 status zero", int'(regRdata), 0);

    // flag bits written as 1 must not set; speed bit reads back
    regWrite(1'b1, 8'h0B);
    @(negedge clk);
    check(regRdata == 8'h08, "R10 status layout, no self-set", int'(regRdata), 8'h08);

    // fast transmit with alternating bits
    sendByte(8'h55, 4);
    waitStatus(1, "R5 transmit done set");
    repeat (20) @(negedge clk);
    check(regRdata[1] == 1'b1, "R5 transmit done sticky", int'(regRdata[1]), 1);
    check(sdOe === 1'b0 && sclk === 1'b1, "R2 pins idle after transmit",
          int'({sdOe, sclk}), 1);
    check(txQ.size() == 0, "R2 all bits seen", txQ.size(), 0);
    regWrite(1'b1, 8'h08);
    @(negedge clk);
    check(regRdata[1] == 1'b0, "R5 transmit done cleared", int'(regRdata[1]), 0);

    // slow transmit; mid-flight data write and speed change both ignored
    regWrite(1'b1, 8'h00);
    sendByte(8'hAA, 12);
    repeat (20) @(negedge clk);
    regWrite(1'b0, 8'h3C);
    regWrite(1'b1, 8'h0B);
    waitStatus(1, "R5 transmit done after slow byte");
    repeat (40) @(negedge clk);
    check(txQ.size() == 0, "R6 single transfer only", txQ.size(), 0);
    check(strayRises == 0, "R6 no extra clocks", strayRises, 0);

    // speed now fast (bit 3 kept by last write)
    regWrite(1'b1, 8'h08);
    sendByte(8'h96, 4);
    waitStatus(1, "R5 transmit done third byte");
    regWrite(1'b1, 8'h08);

    // receive fast, then hold while full
    recvByte(8'hC3, 4, 8'h0C);
    repeat (40) @(negedge clk);
    check(strayRises == 0, "R9 no clock while full", strayRises, 0);
    regAddr = 1'b0;
    @(negedge clk);
    check(regRdata == 8'hC3, "R9 buffer held while full", int'(regRdata), 8'hC3);
    regAddr = 1'b1;
    @(negedge clk);
    st = int'(regRdata);
    check(st == 8'h0D, "R10 status while full", st, 8'h0D);

    // clearing the full flag restarts reception, now slow
    recvByte(8'h5A, 12, 8'h04);
    regWrite(1'b1, 8'h01);
    regWrite(1'b1, 8'h00);
    repeat (30) @(negedge clk);
    check(strayRises == 0, "R9 idle after disable", strayRises, 0);
    check(regRdata == 8'h00, "R9 flags cleared", int'(regRdata), 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++; errCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule